// File: doc/BRIEF.md
# Serial Transfer Queue Sequencer

This block walks a 4-bit pointer through a 16-entry command queue on behalf of a queued serial engine. Software sets a start entry, an end entry, a wraparound enable and a choice of wrap destination, then raises the engine enable. The sequencer then issues one transfer request per queue entry to an external serializer. It waits for that transfer's done strobe and moves to the next entry.

Requests follow valid/ready rules. `req_valid` stays high, and `cur_ptr` stays constant, until the serializer raises `req_ready` on a clock edge. No new request is issued until the serializer returns a one-cycle `xfer_done` pulse for the accepted one. The serializer may hold `req_ready` low for any number of cycles.

The sequencer also reports the most recently completed entry, a sticky end-of-queue flag, a halt-acknowledge level and a sticky mode-fault flag. It produces a gated interrupt request and passes a loopback control straight through to the serializer.

Top module: `xfer_queue_seq`

## Requirements
- R1: After reset, `req_valid`, `cur_ptr`, `cpt_ptr`, `done_flag`, `halt_ack`, `modf_flag` and `irq` are all 0.
- R2: When `enable` is high and the block is idle, sequencing starts at the entry held in `new_ptr`. That value is sampled when the block leaves idle.
- R3: After each completed entry other than the end entry, the pointer advances by one, and 15 rolls over to 0. With `wrap_en`=0, completion of the end entry stops sequencing, and `req_valid` stays 0 until `enable` is dropped.
- R4: With `wrap_en`=1, the entry after the end entry is 0 when `wrap_to_new`=0, and is `new_ptr` when `wrap_to_new`=1.
- R5: On each accepted `xfer_done` pulse, `cpt_ptr` takes the pointer of the transfer that finished. Otherwise it holds its value.
- R6: `done_flag` sets when the end entry's transfer finishes, on every pass in wrap mode. It stays set until a cycle with `clr_done`=1.
- R7: While `halt_req`=1, the in-flight transfer still completes. After its done strobe, `halt_ack`=1, no request is issued and `cur_ptr` keeps the finished entry. Dropping `halt_req` clears `halt_ack` and resumes at the following entry.
- R8: A `mode_fault` pulse during sequencing stops the block at once and sets `modf_flag`. A later `xfer_done` is ignored, so `cpt_ptr` is unchanged. Requests resume only after `enable` goes low and then high. `clr_modf`=1 clears the flag.
- R9: `irq` is high exactly when `irq_en`=1 and at least one of `halt_ack` and `modf_flag` is 1.
- R10: `ser_loop` equals `loop_mode` in every cycle.
- R11: `req_valid` held with `req_ready`=0 stays high with `cur_ptr` unchanged on the next cycle. Each entry is requested exactly once per visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable |
| new_ptr | input | 4 | Start entry and optional wrap destination |
| end_ptr | input | 4 | Last entry of the queue |
| wrap_en | input | 1 | Continue past the end entry |
| wrap_to_new | input | 1 | Wrap destination: 0 = entry 0, 1 = `new_ptr` |
| halt_req | input | 1 | Stop at the next transfer boundary |
| loop_mode | input | 1 | Loopback control for the serializer |
| irq_en | input | 1 | Interrupt enable for halt and mode fault |
| clr_done | input | 1 | Clear pulse for `done_flag` |
| clr_modf | input | 1 | Clear pulse for `modf_flag` |
| mode_fault | input | 1 | Mode-fault pulse |
| req_valid | output | 1 | Transfer request for entry `cur_ptr` |
| req_ready | input | 1 | Serializer accepts the request |
| xfer_done | input | 1 | Accepted transfer has finished |
| ser_loop | output | 1 | Loopback control to the serializer |
| cur_ptr | output | 4 | Current queue entry |
| cpt_ptr | output | 4 | Most recently completed entry |
| done_flag | output | 1 | Sticky end-of-queue flag |
| halt_ack | output | 1 | Halted at a transfer boundary |
| modf_flag | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a mode fault that lands between an accepted request and that transfer's done strobe. In that case the late strobe must change nothing. The stimulus gets there by accepting a request and then pulsing `mode_fault` one cycle before the serializer model pulses `xfer_done`. It then checks that `cpt_ptr` is unchanged and that no request follows until enable is toggled.

Halting works the same way. `halt_req` is raised while a transfer is in flight, so the stop lands exactly on the boundary after that transfer. Resuming must then continue at the following entry.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_HALT,
    S_STOP
  } seq_state_t;
endpackage

// File: rtl/seq_ptr_step.sv
module seq_ptr_step #(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] last,
  input  logic [PTR_W-1:0] start,
  input  logic             wrap_en,
  input  logic             wrap_to_new,
  output logic [PTR_W-1:0] nxt,
  output logic             at_end,
  output logic             stop_now
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_comb begin
    at_end   = (cur == last);
    stop_now = at_end && !wrap_en;
    if (at_end && wrap_en) nxt = wrap_to_new ? start : '0;
    else                   nxt = cur + ONE;
  end
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic             at_end,
  input  logic [PTR_W-1:0] cur,
  input  logic             clr_done,
  input  logic             mf_pulse,
  input  logic             clr_modf,
  output logic [PTR_W-1:0] cpt_ptr,
  output logic             done_flag,
  output logic             modf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpt_ptr   <= '0;
      done_flag <= 1'b0;
      modf_flag <= 1'b0;
    end else begin
      if (done_evt) cpt_ptr <= cur;
      if (done_evt && at_end) done_flag <= 1'b1;
      else if (clr_done)      done_flag <= 1'b0;
      if (mf_pulse)      modf_flag <= 1'b1;
      else if (clr_modf) modf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_queue_seq.sv
module xfer_queue_seq
  import seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PTR_W-1:0] new_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic             wrap_en,
  input  logic             wrap_to_new,
  input  logic             halt_req,
  input  logic             loop_mode,
  input  logic             irq_en,
  input  logic             clr_done,
  input  logic             clr_modf,
  input  logic             mode_fault,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             xfer_done,
  output logic             ser_loop,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [PTR_W-1:0] cpt_ptr,
  output logic             done_flag,
  output logic             halt_ack,
  output logic             modf_flag,
  output logic             irq
);
  seq_state_t state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, nxt;
  logic at_end, stop_now, busy, done_evt;

  seq_ptr_step #(.PTR_W(PTR_W)) u_step (
    .cur(ptr_q), .last(end_ptr), .start(new_ptr),
    .wrap_en(wrap_en), .wrap_to_new(wrap_to_new),
    .nxt(nxt), .at_end(at_end), .stop_now(stop_now)
  );

  assign busy     = (state_q == S_REQ) || (state_q == S_WAIT) || (state_q == S_HALT);
  assign done_evt = (state_q == S_WAIT) && xfer_done && !mode_fault;

  seq_flags #(.PTR_W(PTR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .at_end(at_end),
    .cur(ptr_q), .clr_done(clr_done), .mf_pulse(mode_fault),
    .clr_modf(clr_modf), .cpt_ptr(cpt_ptr), .done_flag(done_flag),
    .modf_flag(modf_flag)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    if (mode_fault && busy) begin
      state_d = S_STOP;
    end else if (!enable) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          state_d = S_REQ;
          ptr_d   = new_ptr;
        end
        S_REQ: if (req_ready) state_d = S_WAIT;
        S_WAIT: if (xfer_done) begin
          if (stop_now)      state_d = S_STOP;
          else if (halt_req) state_d = S_HALT;
          else begin
            state_d = S_REQ;
            ptr_d   = nxt;
          end
        end
        S_HALT: if (!halt_req) begin
          state_d = S_REQ;
          ptr_d   = nxt;
        end
        S_STOP: state_d = S_STOP;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  assign req_valid = (state_q == S_REQ);
  assign cur_ptr   = ptr_q;
  assign halt_ack  = (state_q == S_HALT);
  assign ser_loop  = loop_mode;
  assign irq       = irq_en && (halt_ack || modf_flag);
endmodule

// File: rtl/xfer_queue_seq_chk.sv
module xfer_queue_seq_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             mode_fault,
  input logic             req_valid,
  input logic             req_ready,
  input logic             xfer_done,
  input logic             clr_done,
  input logic             irq_en,
  input logic [PTR_W-1:0] cur_ptr,
  input logic [PTR_W-1:0] cpt_ptr,
  input logic             done_flag,
  input logic             halt_ack,
  input logic             modf_flag,
  input logic             irq
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && enable && !mode_fault) |=> (req_valid && $stable(cur_ptr)));

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack |-> !req_valid);

  p_modf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (modf_flag && !req_valid));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);

  p_cpt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> $stable(cpt_ptr));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (halt_ack || modf_flag)));

  p_irq_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && halt_ack) |-> irq);
endmodule

bind xfer_queue_seq xfer_queue_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode_fault(mode_fault),
  .req_valid(req_valid), .req_ready(req_ready), .xfer_done(xfer_done),
  .clr_done(clr_done), .irq_en(irq_en), .cur_ptr(cur_ptr),
  .cpt_ptr(cpt_ptr), .done_flag(done_flag), .halt_ack(halt_ack),
  .modf_flag(modf_flag), .irq(irq)
);

// File: tb/xfer_queue_seq_tb_top.sv
`timescale 1ns/1ps
module xfer_queue_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 0, wrap_en = 0, wrap_to_new = 0, halt_req = 0, loop_mode = 0;
  logic irq_en = 0, clr_done = 0, clr_modf = 0, mode_fault = 0;
  logic req_ready = 0, xfer_done = 0;
  logic [3:0] new_ptr = 0, end_ptr = 0;
  logic req_valid, ser_loop, done_flag, halt_ack, modf_flag, irq;
  logic [3:0] cur_ptr, cpt_ptr;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  xfer_queue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .new_ptr(new_ptr),
    .end_ptr(end_ptr), .wrap_en(wrap_en), .wrap_to_new(wrap_to_new),
    .halt_req(halt_req), .loop_mode(loop_mode), .irq_en(irq_en),
    .clr_done(clr_done), .clr_modf(clr_modf), .mode_fault(mode_fault),
    .req_valid(req_valid), .req_ready(req_ready), .xfer_done(xfer_done),
    .ser_loop(ser_loop), .cur_ptr(cur_ptr), .cpt_ptr(cpt_ptr),
    .done_flag(done_flag), .halt_ack(halt_ack), .modf_flag(modf_flag),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // serializer model: wait for request, check entry, accept, then finish
  task automatic do_one(input int exp, input string req);
    int n = 0;
    while (!req_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req_valid && cur_ptr == 4'(exp), req, int'(cur_ptr), exp);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    @(negedge clk);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic setup(input logic [3:0] np, input logic [3:0] ep,
                       input logic we, input logic wt);
    enable = 0;
    @(negedge clk);
    new_ptr = np; end_ptr = ep; wrap_en = we; wrap_to_new = wt;
    clr_done = 1; clr_modf = 1;
    @(negedge clk);
    clr_done = 0; clr_modf = 0;
    enable = 1;
  endtask

  // {new[15:12], end[11:8], wrap_en[7], wrap_to_new[6], count[5:0]}
  localparam logic [15:0] VEC [6] = '{
    {4'd2,  4'd5, 1'b0, 1'b0, 6'd4},
    {4'd14, 4'd1, 1'b0, 1'b0, 6'd4},
    {4'd3,  4'd4, 1'b1, 1'b0, 6'd6},
    {4'd6,  4'd7, 1'b1, 1'b1, 6'd5},
    {4'd9,  4'd9, 1'b0, 1'b0, 6'd1},
    {4'd0,  4'd10, 1'b0, 1'b0, 6'd3}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req_valid && cur_ptr == 0 && cpt_ptr == 0, "R1", int'(req_valid), 0);
    chk(!done_flag && !halt_ack && !modf_flag && !irq, "R1", int'(done_flag), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [3:0] np, ep, last;
      logic we, wt, stopped, hit;
      int cnt, e;
      np = VEC[v][15:12]; ep = VEC[v][11:8]; we = VEC[v][7]; wt = VEC[v][6];
      cnt = int'(VEC[v][5:0]);
      setup(np, ep, we, wt);
      e = int'(np); stopped = 0; hit = 0; last = 0;
      for (int i = 0; i < cnt; i++) begin
        do_one(e, (i == 0) ? "R2" : (we ? "R4" : "R3"));
        last = 4'(e);
        if (4'(e) == ep) begin
          hit = 1;
          if (we) e = wt ? int'(np) : 0;
          else stopped = 1;
        end else e = (e + 1) % 16;
      end
      chk(cpt_ptr == last, "R5", int'(cpt_ptr), int'(last));
      chk(done_flag == hit, "R6", int'(done_flag), int'(hit));
      repeat (3) @(negedge clk);
      if (stopped) chk(!req_valid, "R3", int'(req_valid), 0);
      else chk(req_valid && cur_ptr == 4'(e), "R11", int'(cur_ptr), e);
    end

    // R6 clear of the sticky flag
    clr_done = 1;
    @(negedge clk);
    clr_done = 0;
    chk(!done_flag, "R6", int'(done_flag), 0);

    // R10 loopback pass-through
    loop_mode = 1; #1;
    chk(ser_loop == 1'b1, "R10", int'(ser_loop), 1);
    loop_mode = 0; #1;
    chk(ser_loop == 1'b0, "R10", int'(ser_loop), 0);

    // R11 request held under back-pressure
    setup(4'd0, 4'd7, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(req_valid && cur_ptr == 0, "R11", int'(cur_ptr), 0);

    // R7 halt at boundary and resume
    do_one(0, "R2");
    halt_req = 1;
    do_one(1, "R3");
    chk(halt_ack && cur_ptr == 1 && cpt_ptr == 1, "R7", int'(cur_ptr), 1);
    repeat (3) @(negedge clk);
    chk(!req_valid && halt_ack, "R7", int'(req_valid), 0);
    chk(!irq, "R9", int'(irq), 0);
    irq_en = 1; #1;
    chk(irq, "R9", int'(irq), 1);
    halt_req = 0;
    @(negedge clk);
    chk(!halt_ack, "R7", int'(halt_ack), 0);
    do_one(2, "R7");

    // R8 mode fault between accept and done
    while (!req_valid) @(negedge clk);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    mode_fault = 1;
    @(negedge clk);
    mode_fault = 0;
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    chk(modf_flag, "R8", int'(modf_flag), 1);
    chk(cpt_ptr == 2, "R8", int'(cpt_ptr), 2);
    repeat (3) @(negedge clk);
    chk(!req_valid, "R8", int'(req_valid), 0);
    chk(irq, "R9", int'(irq), 1);
    irq_en = 0; #1;
    chk(!irq, "R9", int'(irq), 0);
    clr_modf = 1;
    @(negedge clk);
    clr_modf = 0;
    chk(!modf_flag, "R8", int'(modf_flag), 0);
    enable = 0;
    @(negedge clk);
    new_ptr = 4'd5;
    enable = 1;
    do_one(5, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule